// File: doc/BRIEF.md
# UART Transmit Queue Interrupt Controller

This block is the control and status slice that sits in front of a UART transmitter. Software programs a 16-bit control word, picks a queue trigger level, and writes bytes into a 16-entry transmit queue over a simple single-cycle CPU bus. A transfer stage hands the oldest queued byte to an external serializer whenever transmission is enabled and the serializer is idle. Each time a byte leaves the queue and the remaining count is at or under the trigger level, a low-water flag is raised; the flag, gated by the transmit interrupt enable, drives a level-sensitive interrupt.

The flag cannot be dropped by a plain write. Software must first read the status word while the flag is 1, then write 0 to the flag bit, and the clear is honoured only when the queue has already been refilled past the trigger level. The byte hand-off to the serializer is a valid/ready stream: `ser_valid` is high while transmission is enabled and the queue holds data, `ser_data` is the oldest byte and stays fixed while `ser_ready` is low, and a byte is consumed only in a cycle where both are high. The bus side has no back-pressure: a byte written to a full queue is discarded and recorded in a sticky overflow bit.

Bus map (bus_addr): 0 control word, 1 status word, 2 trigger select, 3 queue data (write-only, reads 0). Status word: bit 0 low-water flag, bit 1 overflow, bits 12:8 queue count, all other bits 0. Trigger select word: bits 1:0, other bits read 0.

Top module: `txq_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000, the trigger select reads 0, the status word reads 0x0001 (flag 1, overflow 0, count 0), `tx_irq` is 0 and `ser_valid` is 0.
- R2: Control word fields: bit 7 transmit interrupt enable, bit 6 receive interrupt enable, bit 5 transmit enable, bit 4 receive enable, bit 3 receive-error interrupt enable, bits 1:0 clock-source select; bits 15:8 and bit 2 always read 0 and ignore writes, so writing 0xFFFF reads back 0x00FB. The stored receive and clock bits appear unchanged on the ctl_* outputs.
- R3: `ser_valid` is 1 exactly when transmit enable is 1 and the queue is non-empty; `ser_data` is the oldest queued byte, stays stable while `ser_valid` is 1 and `ser_ready` is 0, and bytes leave in write order, one per cycle with both high.
- R4: Trigger select 00 means 8, 01 means 4, 10 means 2, 11 means 0. When a byte leaves the queue and the resulting count is at or below the trigger, the flag becomes 1 at that clock edge.
- R5: `tx_irq` is 1 while the flag and the transmit interrupt enable are both 1; clearing the enable drops `tx_irq` from the write edge and leaves the flag value unchanged.
- R6: A status read that returns flag 1, followed by a status write with bit 0 = 0 while the count exceeds the trigger, clears the flag.
- R7: A status write with bit 0 = 0 is ignored if no status read returned flag 1 since the flag was last set, or if the count is at or below the trigger; writing 1 to bit 0 has no effect.
- R8: A data write while the queue holds 16 bytes is discarded and sets the overflow bit; a status write with bit 1 = 0 clears it, bit 1 = 1 leaves it.
- R9: While transmit enable is 0 the flag reads 1, no byte is handed to the serializer, and clear attempts have no effect.
- R10: When a transfer that raises the flag and an accepted-looking clear fall on the same edge, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| ser_valid | output | 1 | A byte is offered to the serializer |
| ser_ready | input | 1 | Serializer idle strobe, accepts the byte |
| ser_data | output | 8 | Oldest queued byte |
| tx_irq | output | 1 | Level transmit interrupt |
| ctl_rx_en | output | 1 | Stored receive enable |
| ctl_rx_irq_en | output | 1 | Stored receive interrupt enable |
| ctl_rxerr_irq_en | output | 1 | Stored receive-error interrupt enable |
| ctl_clk_sel | output | 2 | Stored clock-source select |

## Verification
The two functions that can collide are a transfer that raises the low-water flag and a software clear of that flag. The bench arms the clear with a status read while five bytes are queued under a trigger of four, then in one cycle drives the clear write together with `ser_ready`, so the byte leaves and drops the count to the trigger at the same edge the clear is seen. It judges the outcome by reading status afterwards and expecting flag 1 with count 4.

// File: rtl/txq_pkg.sv
package txq_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  // writable bits of the control word
  localparam logic [15:0] CTRL_WMASK = 16'h00FB;

  localparam int CTL_TIE  = 7;
  localparam int CTL_RIE  = 6;
  localparam int CTL_TE   = 5;
  localparam int CTL_RE   = 4;
  localparam int CTL_REIE = 3;

  localparam int STAT_FLAG = 0;
  localparam int STAT_OVF  = 1;
  localparam int STAT_CNT  = 8;

  typedef struct packed {
    logic       tie;
    logic       rie;
    logic       te;
    logic       re;
    logic       reie;
    logic [1:0] cks;
  } ctl_t;

endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic [$clog2(DEPTH+1)-1:0]   count_next,
  output logic                         full,
  output logic                         empty,
  output logic                         push_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign push_drop = push && full;
  assign head      = mem[rd_ptr];
  assign count     = cnt_q;

  always_comb begin
    count_next = cnt_q;
    if (do_push && !do_pop) count_next = cnt_q + 1'b1;
    else if (!do_push && do_pop) count_next = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt_q <= count_next;
    end
  end

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == CW'(DEPTH)));

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/txq_regs.sv
module txq_regs
  import txq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [15:0]    bus_wdata,
  output logic [15:0]    bus_rdata,
  input  logic           flag,
  input  logic [CW-1:0]  count,
  input  logic           ovf_evt,
  output ctl_t           ctl,
  output logic [1:0]     trig_sel,
  output logic           push,
  output logic [7:0]     push_data,
  output logic           stat_rd,
  output logic           flag_clr_wr
);
  logic [15:0] ctrl_q;
  logic [1:0]  trig_q;
  logic        ovf_q;
  logic        wr_ctrl, wr_stat, wr_trig;

  assign wr_ctrl     = bus_sel && bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat     = bus_sel && bus_wr && (bus_addr == ADDR_STAT);
  assign wr_trig     = bus_sel && bus_wr && (bus_addr == ADDR_TRIG);
  assign push        = bus_sel && bus_wr && (bus_addr == ADDR_DATA);
  assign push_data   = bus_wdata[7:0];
  assign stat_rd     = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
  assign flag_clr_wr = wr_stat && !bus_wdata[STAT_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      trig_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
      if (wr_trig) trig_q <= bus_wdata[1:0];
      if (ovf_evt) ovf_q <= 1'b1;
      else if (wr_stat && !bus_wdata[STAT_OVF]) ovf_q <= 1'b0;
    end
  end

  assign ctl.tie  = ctrl_q[CTL_TIE];
  assign ctl.rie  = ctrl_q[CTL_RIE];
  assign ctl.te   = ctrl_q[CTL_TE];
  assign ctl.re   = ctrl_q[CTL_RE];
  assign ctl.reie = ctrl_q[CTL_REIE];
  assign ctl.cks  = ctrl_q[1:0];
  assign trig_sel = trig_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = ctrl_q;
      ADDR_STAT: begin
        bus_rdata[STAT_FLAG] = flag;
        bus_rdata[STAT_OVF]  = ovf_q;
        bus_rdata[STAT_CNT +: CW] = count;
      end
      ADDR_TRIG: bus_rdata[1:0] = trig_q;
      default:   bus_rdata = '0;
    endcase
  end

  // R2
  ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[15:8] == 8'h00) && !ctrl_q[2]);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !wr_stat) |=> ovf_q);

endmodule

// File: rtl/txq_thr_flag.sv
module txq_thr_flag #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          xfer,
  input  logic [CW-1:0] count_now,
  input  logic [CW-1:0] count_next,
  input  logic [CW-1:0] trig,
  input  logic          stat_rd,
  input  logic          clr_wr,
  output logic          flag
);
  logic flag_q, armed_q;
  logic set_evt, clr_ok;

  assign set_evt = xfer && (count_next <= trig);
  assign clr_ok  = clr_wr && armed_q && (count_now > trig);
  assign flag    = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (!tx_en || set_evt) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0;
    end else if (clr_ok) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stat_rd && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  // R4 / R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R9
  te_off_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> flag_q);

  // R7
  unarmed_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_wr && !armed_q) |=> flag_q);

  // R7
  low_cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_wr && (count_now <= trig)) |=> flag_q);

endmodule

// File: rtl/txq_irq_ctrl.sv
module txq_irq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             ser_valid,
  input  logic             ser_ready,
  output logic [WIDTH-1:0] ser_data,
  output logic             tx_irq,
  output logic             ctl_rx_en,
  output logic             ctl_rx_irq_en,
  output logic             ctl_rxerr_irq_en,
  output logic [1:0]       ctl_clk_sel
);
  localparam int CW = $clog2(DEPTH+1);

  ctl_t          ctl;
  logic [1:0]    trig_sel;
  logic [CW-1:0] trig;
  logic [CW-1:0] count, count_next;
  logic          full, empty, push_drop;
  logic          push, stat_rd, clr_wr, flag, xfer;
  logic [7:0]    push_byte;
  logic [WIDTH-1:0] push_word;

  generate
    if (WIDTH > 8) begin : g_wide
      assign push_word = {{(WIDTH-8){1'b0}}, push_byte};
    end else begin : g_narrow
      assign push_word = push_byte[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    unique case (trig_sel)
      2'b00:   trig = CW'(DEPTH / 2);
      2'b01:   trig = CW'(DEPTH / 4);
      2'b10:   trig = CW'(DEPTH / 8);
      default: trig = '0;
    endcase
  end

  txq_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag(flag), .count(count), .ovf_evt(push_drop),
    .ctl(ctl), .trig_sel(trig_sel),
    .push(push), .push_data(push_byte),
    .stat_rd(stat_rd), .flag_clr_wr(clr_wr)
  );

  txq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_data(push_word),
    .pop(xfer), .head(ser_data),
    .count(count), .count_next(count_next),
    .full(full), .empty(empty), .push_drop(push_drop)
  );

  txq_thr_flag #(.CW(CW)) u_flag (
    .clk(clk), .rst_n(rst_n),
    .tx_en(ctl.te), .xfer(xfer),
    .count_now(count), .count_next(count_next), .trig(trig),
    .stat_rd(stat_rd), .clr_wr(clr_wr),
    .flag(flag)
  );

  assign ser_valid        = ctl.te && !empty;
  assign xfer             = ser_valid && ser_ready;
  assign tx_irq           = flag && ctl.tie;
  assign ctl_rx_en        = ctl.re;
  assign ctl_rx_irq_en    = ctl.rie;
  assign ctl_rxerr_irq_en = ctl.reie;
  assign ctl_clk_sel      = ctl.cks;

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> $stable(ser_data));

  // R3
  no_empty_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> !empty && ctl.te && !full || ser_valid && full);

  // R9
  te_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.te |=> $stable(count) || $past(push));

endmodule

// File: tb/txq_irq_ctrl_tb.sv
`timescale 1ns/1ps
module txq_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ser_valid, ser_ready = 1'b0;
  logic [7:0]  ser_data;
  logic        tx_irq, ctl_rx_en, ctl_rx_irq_en, ctl_rxerr_irq_en;
  logic [1:0]  ctl_clk_sel;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  txq_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .ser_data(ser_data),
    .tx_irq(tx_irq), .ctl_rx_en(ctl_rx_en), .ctl_rx_irq_en(ctl_rx_irq_en),
    .ctl_rxerr_irq_en(ctl_rxerr_irq_en), .ctl_clk_sel(ctl_clk_sel)
  );

  // vector: {trigger select[1:0], bytes pushed[4:0], bytes popped[4:0]}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 5'd12, 5'd3}, {2'd0, 5'd12, 5'd4}, {2'd1, 5'd6, 5'd1},
    {2'd1, 5'd6, 5'd2},  {2'd2, 5'd3, 5'd1},  {2'd3, 5'd1, 5'd0},
    {2'd3, 5'd2, 5'd2},  {2'd0, 5'd8, 5'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    ser_ready = 1'b1;
    @(negedge clk);
    ser_ready = 1'b0;
  endtask

  task automatic drain();
    while (ser_valid) pop_one();
  endtask

  task automatic push_n(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) bus_write(2'd3, {8'h00, base + 8'(i)});
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] r;
    int trig;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd0, r); check("R1 ctrl", r, 16'h0000);
    bus_read(2'd2, r); check("R1 trig", r, 16'h0000);
    bus_read(2'd1, r); check("R1 status", r, 16'h0001);
    check("R1 irq", {15'b0, tx_irq}, 16'h0000);
    check("R1 valid", {15'b0, ser_valid}, 16'h0000);

    // R4 / R6 table walk over trigger encodings
    for (int v = 0; v < 8; v++) begin
      logic [1:0] sel;
      int n, k;
      logic exp_clr, exp_end;
      sel = VEC[v][11:10]; n = int'(VEC[v][9:5]); k = int'(VEC[v][4:0]);
      case (sel)
        2'd0: trig = 8; 2'd1: trig = 4; 2'd2: trig = 2; default: trig = 0;
      endcase
      exp_clr = (n <= trig);
      exp_end = exp_clr || (k > 0 && (n - k) <= trig);
      bus_write(2'd0, 16'h0000);
      bus_write(2'd2, {14'b0, sel});
      push_n(n, 8'h10);
      bus_write(2'd0, 16'h0020);
      bus_read(2'd1, r);
      bus_write(2'd1, 16'h0002);
      bus_read(2'd1, r);
      check("R6 clear by handshake", {15'b0, r[0]}, {15'b0, exp_clr});
      check("R6 count", {11'b0, r[12:8]}, 16'(n));
      repeat (k) pop_one();
      bus_read(2'd1, r);
      check("R4 flag after transfers", {15'b0, r[0]}, {15'b0, exp_end});
      drain();
    end

    // R2 control field access
    bus_write(2'd0, 16'hFFFF);
    bus_read(2'd0, r); check("R2 ctrl mask", r, 16'h00FB);
    check("R2 outputs", {12'b0, ctl_rx_en, ctl_rx_irq_en, ctl_rxerr_irq_en, 1'b0}, 16'h000E);
    check("R2 clk_sel", {14'b0, ctl_clk_sel}, 16'h0003);
    bus_write(2'd0, 16'h0000);

    // R9 transmit disabled
    bus_write(2'd2, 16'h0003);
    push_n(3, 8'h20);
    ser_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 no offer", {15'b0, ser_valid}, 16'h0000);
    ser_ready = 1'b0;
    bus_read(2'd1, r);
    bus_write(2'd1, 16'h0002);
    bus_read(2'd1, r); check("R9 flag held count kept", r, 16'h0301);

    // R3 order and hold
    bus_write(2'd0, 16'h0020);
    check("R3 valid", {15'b0, ser_valid}, 16'h0001);
    check("R3 head", {8'h00, ser_data}, 16'h0020);
    repeat (3) @(negedge clk);
    check("R3 hold", {8'h00, ser_data}, 16'h0020);
    for (int i = 0; i < 3; i++) begin
      check("R3 order", {8'h00, ser_data}, 16'h0020 + 16'(i));
      pop_one();
    end
    check("R3 empty no offer", {15'b0, ser_valid}, 16'h0000);

    // R7 / R6 / R5 with trigger 0; flag was set by last transfer
    bus_write(2'd0, 16'h00A0);
    check("R5 irq on", {15'b0, tx_irq}, 16'h0001);
    push_n(2, 8'h30);
    bus_write(2'd1, 16'h0002);
    check("R7 unarmed clear ignored", {15'b0, tx_irq}, 16'h0001);
    bus_write(2'd1, 16'h0003);
    check("R7 write one no effect", {15'b0, tx_irq}, 16'h0001);
    bus_read(2'd1, r);
    bus_write(2'd1, 16'h0002);
    check("R6 armed clear", {15'b0, tx_irq}, 16'h0000);
    pop_one();
    check("R4 above trigger no set", {15'b0, tx_irq}, 16'h0000);
    pop_one();
    check("R4 at trigger sets", {15'b0, tx_irq}, 16'h0001);
    bus_write(2'd0, 16'h0020);
    check("R5 irq masked", {15'b0, tx_irq}, 16'h0000);
    bus_read(2'd1, r); check("R5 flag kept", {15'b0, r[0]}, 16'h0001);
    bus_write(2'd0, 16'h00A0);
    check("R5 irq back", {15'b0, tx_irq}, 16'h0001);

    // R7 armed but count at trigger
    bus_write(2'd2, 16'h0000);
    push_n(4, 8'h40);
    bus_read(2'd1, r);
    bus_write(2'd1, 16'h0002);
    check("R7 low count clear ignored", {15'b0, tx_irq}, 16'h0001);
    drain();

    // R8 overflow
    bus_write(2'd0, 16'h0000);
    push_n(16, 8'h50);
    bus_write(2'd3, 16'h0099);
    bus_read(2'd1, r); check("R8 full and overflow", r, 16'h1003);
    bus_write(2'd1, 16'h0003);
    bus_read(2'd1, r); check("R8 overflow kept by one", {15'b0, r[1]}, 16'h0001);
    bus_write(2'd1, 16'h0001);
    bus_read(2'd1, r); check("R8 overflow cleared", r, 16'h1001);
    bus_write(2'd0, 16'h0020);
    for (int i = 0; i < 16; i++) begin
      check("R8 dropped byte absent", {8'h00, ser_data}, 16'h0050 + 16'(i));
      pop_one();
    end
    check("R8 drained", {15'b0, ser_valid}, 16'h0000);

    // R10 set and clear on the same edge, trigger 4
    bus_write(2'd0, 16'h0000);
    bus_write(2'd2, 16'h0001);
    push_n(5, 8'h60);
    bus_write(2'd0, 16'h0020);
    bus_read(2'd1, r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'h0002;
    ser_ready = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; ser_ready = 1'b0;
    bus_read(2'd1, r); check("R10 set wins", r, 16'h0401);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule